// File: doc/BRIEF.md
# Serial receiver start and frame-sync controller

This block decides, cycle by cycle on the receive clock, when a synchronous serial receiver begins capturing a word and when it stops. It selects one of nine start conditions: free-running, a strobe from the transmitter, a level on the frame-sync input, an edge on the frame-sync input, or a compare-0 pattern match. An optional start delay is inserted between the start event and the first active cycle. When the trigger is a compare-0 match, a stop mode chooses between receiving one word and receiving continuously until a compare-1 match.

The block also produces a one-cycle frame-sync pulse at a programmable period while the receiver is enabled. The data shifter, the pattern comparators, register access and clock selection sit outside this block. The shifter reports the end of each word with `word_done`.

Top module: `rx_start_ctrl`

## Requirements
- R1: While `rx_en` is low, `rx_active`, `rx_start` and `fsync_out` are low, and any pending delay, armed continuous state and period count are discarded. After re-enabling, the period count starts again from zero.
- R2: Start select 0 (continuous) starts as soon as the receiver is enabled. At each `word_done` it restarts at once: with zero delay `rx_active` stays high and `rx_start` pulses again.
- R3: Start select 1 starts on a `tx_start` strobe. After `word_done` the receiver returns to idle.
- R4: Start select 2 starts while `fsync_in` is low and select 3 starts while it is high. After `word_done` the receiver spends one cycle idle, then restarts if the level still holds.
- R5: Start selects 4 (falling), 5 (rising), 6 and 7 (either direction) start on a change of `fsync_in` relative to its value sampled on the previous clock. An edge starts one word only, and a held level does not retrigger.
- R6: Start select values 9 to 15 never start a reception.
- R7: With delay D, the first `rx_active` cycle comes D clocks later than it would with delay 0. With delay 0, `rx_active` is high in the cycle right after the edge that samples the start event.
- R8: A start event that arrives during a delay countdown or an active word is ignored.
- R9: Start select 8 with stop mode 0 starts on `cmp0_hit`, receives one word, then waits for a new `cmp0_hit`. `cmp1_hit` has no effect.
- R10: Start select 8 with stop mode 1 starts on `cmp0_hit` and restarts at every `word_done` until a `cmp1_hit` is seen. The word in progress then completes and the receiver returns to waiting for compare 0.
- R11: Period value 0 keeps `fsync_out` low. A value N greater than 0 gives a one-cycle `fsync_out` pulse every 2*(N+1) clocks, the first one 2*(N+1) clocks after enabling.
- R12: `rx_start` is a one-cycle pulse in the first active cycle of each word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start_sel | input | 4 | Start condition select (0..8 used, 9..15 reserved) |
| cfg_stop_mode | input | 1 | 0: one word per compare-0, 1: continuous until compare-1 |
| cfg_delay | input | 8 | Start delay in receive clocks |
| cfg_period | input | 8 | Frame-sync period divider, 0 disables |
| rx_en | input | 1 | Receiver enable |
| fsync_in | input | 1 | External frame-sync input |
| tx_start | input | 1 | Transmitter start strobe |
| cmp0_hit | input | 1 | Compare-0 match strobe |
| cmp1_hit | input | 1 | Compare-1 match strobe |
| word_done | input | 1 | End-of-word strobe from the shifter |
| rx_active | output | 1 | Reception in progress |
| rx_start | output | 1 | Start-of-reception pulse |
| fsync_out | output | 1 | Generated frame-sync pulse |

## Verification
A wrong state-machine state or delay count shows up as `rx_active` rising one or more clocks early or late after a start event, or rising on a reserved or non-matching condition. Because every state change is one register away from the ports, this is visible in the first cycle after the faulty edge. A stuck armed flag makes the receiver keep restarting after `word_done` when it should idle, and a wrong period count shifts the first `fsync_out` pulse away from clock 2*(N+1) after enable. The sweeps time each of these against cycle counts computed from the configuration.

// File: rtl/rx_start_ctrl.sv
module rx_start_ctrl #(
  parameter int SEL_W = 4,
  parameter int DLY_W = 8,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] cfg_start_sel,
  input  logic             cfg_stop_mode,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [PER_W-1:0] cfg_period,
  input  logic             rx_en,
  input  logic             fsync_in,
  input  logic             tx_start,
  input  logic             cmp0_hit,
  input  logic             cmp1_hit,
  input  logic             word_done,
  output logic             rx_active,
  output logic             rx_start,
  output logic             fsync_out
);

  localparam int PCNT_W = PER_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;

  st_t              st;
  logic [DLY_W-1:0] dcnt;
  logic [PCNT_W-1:0] pcnt;
  logic             fs_q, armed, trig, again, go;

  wire [PCNT_W-1:0] plast = {cfg_period, 1'b1};
  wire sel_cmp = (cfg_start_sel == SEL_W'(8));

  always_comb begin
    case (cfg_start_sel)
      SEL_W'(0): trig = 1'b1;
      SEL_W'(1): trig = tx_start;
      SEL_W'(2): trig = ~fsync_in;
      SEL_W'(3): trig = fsync_in;
      SEL_W'(4): trig = fs_q & ~fsync_in;
      SEL_W'(5): trig = ~fs_q & fsync_in;
      SEL_W'(6),
      SEL_W'(7): trig = fs_q ^ fsync_in;
      SEL_W'(8): trig = cmp0_hit;
      default:   trig = 1'b0;
    endcase
  end

  assign again = (cfg_start_sel == '0) | (armed & ~cmp1_hit);
  assign go = (st == S_IDLE & trig) | (st == S_RUN & word_done & again);
  assign rx_active = (st == S_RUN);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= fsync_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             armed <= 1'b0;
    else if (!rx_en)        armed <= 1'b0;
    else if (cmp1_hit)      armed <= 1'b0;
    else if (st == S_IDLE && trig && sel_cmp && cfg_stop_mode) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dcnt <= '0; rx_start <= 1'b0;
    end else if (!rx_en) begin
      st <= S_IDLE; dcnt <= '0; rx_start <= 1'b0;
    end else begin
      rx_start <= 1'b0;
      if (st == S_WAIT) begin
        if (dcnt == '0) begin
          st <= S_RUN; rx_start <= 1'b1;
        end else dcnt <= dcnt - DLY_W'(1);
      end else if (go) begin
        if (cfg_delay == '0) begin
          st <= S_RUN; rx_start <= 1'b1;
        end else begin
          st <= S_WAIT; dcnt <= cfg_delay - DLY_W'(1);
        end
      end else if (st == S_RUN && word_done) st <= S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0; fsync_out <= 1'b0;
    end else if (!rx_en || cfg_period == '0) begin
      pcnt <= '0; fsync_out <= 1'b0;
    end else if (pcnt >= plast) begin
      pcnt <= '0; fsync_out <= 1'b1;
    end else begin
      pcnt <= pcnt + PCNT_W'(1); fsync_out <= 1'b0;
    end
  end

  a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_active && !rx_start && !fsync_out));

  a_r6_reserved_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cfg_start_sel > SEL_W'(8)) |=> !rx_start);

  a_r7_wait_not_active: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && dcnt != '0 && rx_en) |=> !rx_active);

  a_r7_zero_delay_level: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && rx_en && cfg_start_sel == SEL_W'(3) && fsync_in && cfg_delay == '0) |=> rx_start);

  a_r11_period_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_period == '0) |=> !fsync_out);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_out |=> !fsync_out);

  a_r12_start_in_active: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |-> rx_active);

endmodule

// File: tb/rx_start_ctrl_test.sv
module rx_start_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [3:0] cfg_start_sel = 0;
  logic cfg_stop_mode = 0;
  logic [7:0] cfg_delay = 0, cfg_period = 0;
  logic rx_en = 0, fsync_in = 0, tx_start = 0, cmp0_hit = 0, cmp1_hit = 0, word_done = 0;
  logic rx_active, rx_start, fsync_out;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  rx_start_ctrl uut (.*);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go_idle;
    rx_en = 0; tx_start = 0; cmp0_hit = 0; cmp1_hit = 0; word_done = 0;
    tick; tick;
  endtask

  task automatic wd;
    word_done = 1; tick; word_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, first_bad, any;
    repeat (3) tick;
    rst_n = 1; tick;
    chk("R1 reset active", rx_active, 0);
    chk("R1 reset fsync", fsync_out, 0);
    chk("R1 reset start", rx_start, 0);

    // R3 / R7 / R8 / R12: transmitter start with several delays
    foreach (cfg_delay_set[i]) ;
    for (int di = 0; di < 4; di++) begin
      int d;
      d = (di == 3) ? 5 : di;
      go_idle; cfg_start_sel = 1; cfg_delay = 8'(d); rx_en = 1; tick;
      chk("R3 idle before strobe", rx_active, 0);
      tx_start = 1; tick; tx_start = 0;
      n = 0;
      while (!rx_active && n < 20) begin
        if (n == 0) tx_start = 1;
        tick; tx_start = 0; n++;
      end
      chk("R7 delay cycles", n, d);
      chk("R12 start pulse", rx_start, 1);
      tick;
      chk("R12 pulse one cycle", rx_start, 0);
      tx_start = 1; tick; tx_start = 0;
      chk("R8 ignored while active", rx_start, 0);
      wd;
      chk("R3 idle after word", rx_active, 0);
      any = 0;
      for (int k = 0; k < 8; k++) begin tick; any |= rx_active; end
      chk("R8 no late start from ignored strobe", any, 0);
    end

    // R2 continuous
    go_idle; cfg_start_sel = 0; cfg_delay = 0; rx_en = 1; tick;
    chk("R2 start on enable", rx_active, 1);
    tick;
    wd;
    chk("R2 stays active", rx_active, 1);
    chk("R2 restart pulse", rx_start, 1);
    go_idle; cfg_delay = 2; rx_en = 1;
    tick; chk("R7 cont delay c1", rx_active, 0);
    tick; chk("R7 cont delay c2", rx_active, 0);
    tick; chk("R2 cont delayed start", rx_active, 1);
    wd; chk("R2 delayed restart c0", rx_active, 0);
    tick; chk("R2 delayed restart c1", rx_active, 0);
    tick; chk("R2 delayed restart c2", rx_active, 1);

    // R4 levels
    go_idle; cfg_delay = 0; cfg_start_sel = 3; fsync_in = 1; rx_en = 1; tick;
    chk("R4 high level start", rx_active, 1);
    wd; chk("R4 idle gap", rx_active, 0);
    tick; chk("R4 high retrigger", rx_active, 1);
    fsync_in = 0; wd; tick; tick;
    chk("R4 no retrigger when level gone", rx_active, 0);
    go_idle; cfg_start_sel = 2; fsync_in = 0; rx_en = 1; tick;
    chk("R4 low level start", rx_active, 1);
    fsync_in = 1; wd; tick; tick;
    chk("R4 low level gone", rx_active, 0);

    // R5 edges
    for (int s = 4; s <= 7; s++)
      for (int dir = 0; dir < 2; dir++) begin
        int e;
        fsync_in = dir[0]; cfg_start_sel = 4'(s);
        go_idle; rx_en = 1; tick; tick;
        chk("R5 no start on steady level", rx_active, 0);
        fsync_in = ~fsync_in; tick;
        e = (s == 4) ? dir : (s == 5) ? (dir == 0) : 1;
        chk($sformatf("R5 edge sel%0d dir%0d", s, dir), rx_active, e);
        if (rx_active) begin
          wd; tick; tick;
          chk("R5 single event", rx_active, 0);
        end
      end

    // R6 reserved
    for (int s = 9; s <= 15; s++) begin
      cfg_start_sel = 4'(s); go_idle; rx_en = 1; any = 0;
      for (int i = 0; i < 8; i++) begin
        fsync_in = i[0]; tx_start = 1; cmp0_hit = 1; tick; any |= rx_active;
      end
      tx_start = 0; cmp0_hit = 0;
      chk($sformatf("R6 reserved sel%0d", s), any, 0);
    end

    // R9 compare-0 one shot
    go_idle; cfg_start_sel = 8; cfg_stop_mode = 0; cfg_delay = 0; rx_en = 1; tick;
    chk("R9 waits", rx_active, 0);
    cmp0_hit = 1; tick; cmp0_hit = 0;
    chk("R9 start", rx_active, 1);
    wd; tick; tick;
    chk("R9 one word", rx_active, 0);
    cmp1_hit = 1; tick; cmp1_hit = 0;
    chk("R9 cmp1 no effect", rx_active, 0);

    // R10 continuous until compare-1
    go_idle; cfg_stop_mode = 1; rx_en = 1;
    cmp0_hit = 1; tick; cmp0_hit = 0;
    chk("R10 start", rx_active, 1);
    tick; wd;
    chk("R10 continue", rx_active, 1);
    chk("R10 restart pulse", rx_start, 1);
    wd;
    chk("R10 second restart", rx_start, 1);
    cmp1_hit = 1; tick; cmp1_hit = 0;
    chk("R10 word completes", rx_active, 1);
    wd;
    chk("R10 stop after cmp1", rx_active, 0);
    tick; tick;
    chk("R10 back to waiting", rx_active, 0);

    // R11 period
    for (int pi = 0; pi < 4; pi++) begin
      int nv, len;
      nv = (pi == 0) ? 0 : (1 << pi) - 1;
      len = 2 * (nv + 1);
      cfg_start_sel = 15; go_idle; cfg_period = 8'(nv); rx_en = 1;
      first_bad = -1;
      for (int i = 1; i <= 3 * len + 2; i++) begin
        tick;
        if (first_bad < 0 && fsync_out != (nv != 0 && i % len == 0)) first_bad = i;
      end
      chk($sformatf("R11 period N=%0d first mismatch tick", nv), first_bad, -1);
    end

    // R1 disable mid-operation
    go_idle; cfg_start_sel = 0; cfg_period = 1; rx_en = 1; tick; tick; tick;
    rx_en = 0; tick;
    chk("R1 disable active", rx_active, 0);
    chk("R1 disable fsync", fsync_out, 0);
    rx_en = 1; tick; tick; tick;
    chk("R1 period restarts c3", fsync_out, 0);
    tick;
    chk("R1 period restarts c4", fsync_out, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  int cfg_delay_set[1];
endmodule